// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a processor as a fast interrupt and a normal interrupt. Each source's request is the OR of its hardware line and a software-forced bit. A per-source enable mask gates the request, and a per-source route bit sends it to the fast output or the normal output. All of these are set and cleared through a simple word-addressed register bus.

Normal interrupts can be vectored. Each of a set of prioritized slots claims one source and holds a handler address, and a default handler address covers every pending source that no enabled slot claims. The processor reads the current-vector register to fetch the handler of the winning request. That read also records the winner's priority level on an in-service stack, so only strictly higher-priority slots can preempt until software writes the current-vector register to mark the end of service. A protection bit can limit all writes to privileged bus cycles. Four identification registers return fixed bytes, and these bytes include a vendor code.

The bus has one cycle of access: `bus_sel` with `bus_write` high writes at the clock edge. `bus_sel` with `bus_write` low reads, and `bus_rdata` is valid within the same cycle. Offsets are byte addresses with bits 1:0 ignored.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Writing the enable-set register (0x010) ORs the written bits into the enable mask. Writing the enable-clear register (0x014) removes the written bits. Zero bits change nothing. Reading 0x010 returns the mask.
- R2: Writing the software-set register (0x018) forces sources active, and writing the software-clear register (0x01C) removes those bits. A source's request is its line OR its software bit. The raw register (0x008) shows all requests regardless of enable.
- R3: Route register 0x00C sends an enabled request to `fiq_out` when its bit is 1 and to `irq_out` when it is 0. The masked normal and fast requests read at 0x000 and 0x004.
- R4: Slot i has a control register at 0x200+4i (source index in bits 4:0, enable in bit 5) and a handler address at 0x100+4i. When idle, a read of the current-vector register (0x030) returns the address of the lowest-numbered enabled slot whose source has a pending normal request.
- R5: When no enabled slot claims any pending normal source and nothing is in service, a read of 0x030 returns the default address (0x034).
- R6: Reading 0x030 with a winner pushes the winner's level. While a level is in service, only a slot with a lower number can win, and otherwise the read returns the default address and pushes nothing. A write to 0x030 pops the most recent level.
- R7: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return identification bytes 0 to 3 in bits 7:0. When these bytes are joined with byte 0 as the least significant, bits 19:12 of the word hold the vendor code (default 0x5A). The default word is 0x00B5A1C3.
- R8: When protection bit 0 of register 0x020 is set, writes with `bus_priv` low are ignored.
- R9: After reset, the enable, software, route, protection and slot registers and the default address are zero, and both outputs are low.
- R10: A slot whose enable bit is 0 claims no source, so that source is served through the default address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lines | input | NSRC | Hardware interrupt lines, active high |
| bus_sel | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The assertions check on every cycle that set and clear writes touch exactly the written enable bits, that unprivileged writes leave state unchanged while protection is set, that the fast output stays low when no source is routed to it, and that every push onto the in-service stack is a strictly higher priority and then becomes the current level. The correct handler address for each pattern of pending sources, the blocking and preemption sequence across several reads and writes, the default fallback, and the identification bytes depend on sequences of bus traffic, so only the bench's directed scenarios can show them.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam logic [11:0] A_IRQ_STAT = 12'h000;
   localparam logic [11:0] A_FIQ_STAT = 12'h004;
   localparam logic [11:0] A_RAW_STAT = 12'h008;
   localparam logic [11:0] A_ROUTE    = 12'h00C;
   localparam logic [11:0] A_EN_SET   = 12'h010;
   localparam logic [11:0] A_EN_CLR   = 12'h014;
   localparam logic [11:0] A_SW_SET   = 12'h018;
   localparam logic [11:0] A_SW_CLR   = 12'h01C;
   localparam logic [11:0] A_PROTECT  = 12'h020;
   localparam logic [11:0] A_CUR_VEC  = 12'h030;
   localparam logic [11:0] A_DEF_VEC  = 12'h034;
   localparam logic [3:0]  R_SLOT_VA  = 4'h1;
   localparam logic [3:0]  R_SLOT_CTL = 4'h2;
   localparam logic [7:0]  R_IDENT    = 8'hFE;

   typedef struct packed {
      logic       en;
      logic [4:0] src;
   } slot_ctl_t;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] hw_lines,
   input  logic            we_en_set,
   input  logic            we_en_clr,
   input  logic            we_sw_set,
   input  logic            we_sw_clr,
   input  logic            we_route,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] en_mask,
   output logic [NSRC-1:0] sw_mask,
   output logic [NSRC-1:0] route_mask,
   output logic [NSRC-1:0] raw_req,
   output logic [NSRC-1:0] irq_pend,
   output logic [NSRC-1:0] fiq_pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_mask    <= '0;
         sw_mask    <= '0;
         route_mask <= '0;
      end else begin
         if (we_en_set)      en_mask <= en_mask | wdata;
         else if (we_en_clr) en_mask <= en_mask & ~wdata;
         if (we_sw_set)      sw_mask <= sw_mask | wdata;
         else if (we_sw_clr) sw_mask <= sw_mask & ~wdata;
         if (we_route)       route_mask <= wdata;
      end
   end

   assign raw_req  = hw_lines | sw_mask;
   assign irq_pend = raw_req & en_mask & ~route_mask;
   assign fiq_pend = raw_req & en_mask & route_mask;

   // R1: set writes add exactly the written bits
   p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      we_en_set |=> ((en_mask & $past(wdata)) == $past(wdata)) &&
                    ((en_mask & ~$past(wdata)) == ($past(en_mask) & ~$past(wdata))));
   // R1: clear writes remove exactly the written bits
   p_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (we_en_clr && !we_en_set) |=> ((en_mask & $past(wdata)) == '0) &&
                    ((en_mask & ~$past(wdata)) == ($past(en_mask) & ~$past(wdata))));
   // R2: soft clear leaves no forced bit written as one
   p_sw_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_sw_clr && !we_sw_set) |=> ((sw_mask & $past(wdata)) == '0));
endmodule

// File: rtl/vic_vec_slots.sv
module vic_vec_slots
   import vic_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int NSLOT = 16,
   parameter int DW    = 32,
   parameter int LVL_W = $clog2(NSLOT + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [11:0]      addr,
   input  logic [DW-1:0]    wdata,
   input  logic [NSRC-1:0]  irq_pend,
   input  logic [LVL_W-1:0] cur_level,
   output logic             rd_hit,
   output logic [DW-1:0]    rd_data,
   output logic [DW-1:0]    def_addr,
   output logic             win_valid,
   output logic [LVL_W-1:0] win_level,
   output logic [DW-1:0]    win_addr
);
   localparam int IDX_W = 6;
   localparam logic [LVL_W-1:0] LVL_DEF  = LVL_W'(NSLOT);
   localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NSLOT + 1);

   slot_ctl_t     ctl_q [NSLOT];
   logic [DW-1:0] va_q  [NSLOT];
   logic [DW-1:0] def_q;

   logic [IDX_W-1:0] idx;
   logic             in_range, is_va, is_ctl;
   assign idx      = addr[7:2];
   assign in_range = (32'(idx) < NSLOT);
   assign is_va    = (addr[11:8] == R_SLOT_VA)  && in_range;
   assign is_ctl   = (addr[11:8] == R_SLOT_CTL) && in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         def_q <= '0;
         for (int i = 0; i < NSLOT; i++) begin
            ctl_q[i] <= '0;
            va_q[i]  <= '0;
         end
      end else if (wr_en) begin
         if ({addr[11:2], 2'b00} == A_DEF_VEC) def_q <= wdata;
         for (int i = 0; i < NSLOT; i++) begin
            if (is_va  && (32'(idx) == i)) va_q[i]  <= wdata;
            if (is_ctl && (32'(idx) == i)) ctl_q[i] <= slot_ctl_t'(wdata[5:0]);
         end
      end
   end

   assign def_addr = def_q;

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      if ({addr[11:2], 2'b00} == A_DEF_VEC) begin
         rd_hit  = 1'b1;
         rd_data = def_q;
      end
      for (int i = 0; i < NSLOT; i++) begin
         if (is_va && (32'(idx) == i)) begin
            rd_hit  = 1'b1;
            rd_data = va_q[i];
         end
         if (is_ctl && (32'(idx) == i)) begin
            rd_hit  = 1'b1;
            rd_data = DW'({ctl_q[i].en, ctl_q[i].src});
         end
      end
   end

   // per-slot match and claimed-source map
   logic [31:0]      pend_pad;
   logic [NSLOT-1:0] slot_hit;
   logic [31:0]      claim_pad;
   assign pend_pad = 32'(irq_pend);

   genvar g;
   generate
      for (g = 0; g < NSLOT; g++) begin : g_match
         assign slot_hit[g] = ctl_q[g].en && pend_pad[ctl_q[g].src];
      end
   endgenerate

   always_comb begin
      claim_pad = '0;
      for (int i = 0; i < NSLOT; i++)
         if (ctl_q[i].en) claim_pad[ctl_q[i].src] = 1'b1;
   end

   logic             best_ok;
   logic [LVL_W-1:0] best;
   logic             unclaimed;
   always_comb begin
      best_ok = 1'b0;
      best    = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (slot_hit[i]) begin
            best_ok = 1'b1;
            best    = LVL_W'(i);
         end
      end
   end
   assign unclaimed = |(pend_pad & ~claim_pad);

   always_comb begin
      win_valid = 1'b0;
      win_level = LVL_IDLE;
      win_addr  = def_q;
      if (best_ok && (best < cur_level)) begin
         win_valid = 1'b1;
         win_level = best;
         for (int i = 0; i < NSLOT; i++)
            if (best == LVL_W'(i)) win_addr = va_q[i];
      end else if (unclaimed && (cur_level == LVL_IDLE)) begin
         win_valid = 1'b1;
         win_level = LVL_DEF;
      end
   end

   // R4: a slot winner always beats the level in service
   p_win_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_level < cur_level));
   // R10: a disabled slot never supplies the winner
   p_slot_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && (win_level < LVL_DEF)) |-> ctl_q[win_level[IDX_W-1:0]].en);
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
   parameter int NSLOT = 16,
   parameter int LVL_W = $clog2(NSLOT + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LVL_W-1:0] push_level,
   input  logic             pop,
   output logic [LVL_W-1:0] cur_level
);
   localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NSLOT + 1);

   logic [NSLOT:0] active_q;

   always_comb begin
      cur_level = LVL_IDLE;
      for (int i = NSLOT; i >= 0; i--)
         if (active_q[i]) cur_level = LVL_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= '0;
      end else begin
         for (int i = 0; i <= NSLOT; i++) begin
            if (push && (push_level == LVL_W'(i)))
               active_q[i] <= 1'b1;
            else if (!push && pop && (cur_level == LVL_W'(i)))
               active_q[i] <= 1'b0;
         end
      end
   end

   // R6: only a strictly higher priority may be pushed
   p_push_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (push_level < cur_level));
   // R6: a pushed level becomes the current level
   p_push_current_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (cur_level == $past(push_level)));
   // R6: a pop retires exactly one level
   p_pop_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && (active_q != '0)) |=>
         ($countones(active_q) + 1 == $countones($past(active_q))));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int          NSRC   = 32,
   parameter int          NSLOT  = 16,
   parameter logic [7:0]  VENDOR = 8'h5A,
   parameter logic [11:0] PART   = 12'h1C3,
   parameter logic [11:0] REV    = 12'h00B
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_lines,
   input  logic            bus_sel,
   input  logic            bus_write,
   input  logic            bus_priv,
   input  logic [11:0]     bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            irq_out,
   output logic            fiq_out
);
   localparam int DW    = 32;
   localparam int LVL_W = $clog2(NSLOT + 2);
   localparam logic [31:0] ID_WORD = {REV, VENDOR, PART};

   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
         $error("vec_irq_ctrl: NSRC must be 1..32");
      end
      if (NSLOT < 1 || NSLOT > 64) begin : g_bad_nslot
         $error("vec_irq_ctrl: NSLOT must be 1..64");
      end
   endgenerate

   logic [11:0] a;
   logic        prot_q;
   logic        wr_ok, rd_ok;
   assign a     = {bus_addr[11:2], 2'b00};
   assign wr_ok = bus_sel && bus_write && (!prot_q || bus_priv);
   assign rd_ok = bus_sel && !bus_write;

   always_ff @(posedge clk) begin
      if (!rst_n)                        prot_q <= 1'b0;
      else if (wr_ok && a == A_PROTECT)  prot_q <= bus_wdata[0];
   end

   logic [NSRC-1:0] en_mask, sw_mask, route_mask, raw_req, irq_pend, fiq_pend;

   vic_src_bank #(.NSRC(NSRC)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_lines   (src_lines),
      .we_en_set  (wr_ok && a == A_EN_SET),
      .we_en_clr  (wr_ok && a == A_EN_CLR),
      .we_sw_set  (wr_ok && a == A_SW_SET),
      .we_sw_clr  (wr_ok && a == A_SW_CLR),
      .we_route   (wr_ok && a == A_ROUTE),
      .wdata      (bus_wdata[NSRC-1:0]),
      .en_mask    (en_mask),
      .sw_mask    (sw_mask),
      .route_mask (route_mask),
      .raw_req    (raw_req),
      .irq_pend   (irq_pend),
      .fiq_pend   (fiq_pend)
   );

   logic             slot_rd_hit, win_valid;
   logic [DW-1:0]    slot_rd_data, def_addr, win_addr;
   logic [LVL_W-1:0] win_level, cur_level;
   logic             push, pop;

   vic_vec_slots #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .LVL_W(LVL_W)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_ok),
      .addr      (a),
      .wdata     (bus_wdata),
      .irq_pend  (irq_pend),
      .cur_level (cur_level),
      .rd_hit    (slot_rd_hit),
      .rd_data   (slot_rd_data),
      .def_addr  (def_addr),
      .win_valid (win_valid),
      .win_level (win_level),
      .win_addr  (win_addr)
   );

   assign push = rd_ok && (a == A_CUR_VEC) && win_valid;
   assign pop  = wr_ok && (a == A_CUR_VEC);

   vic_prio_stack #(.NSLOT(NSLOT), .LVL_W(LVL_W)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_level (win_level),
      .pop        (pop),
      .cur_level  (cur_level)
   );

   assign irq_out = |irq_pend;
   assign fiq_out = |fiq_pend;

   always_comb begin
      bus_rdata = '0;
      case (a)
         A_IRQ_STAT: bus_rdata = 32'(irq_pend);
         A_FIQ_STAT: bus_rdata = 32'(fiq_pend);
         A_RAW_STAT: bus_rdata = 32'(raw_req);
         A_ROUTE:    bus_rdata = 32'(route_mask);
         A_EN_SET:   bus_rdata = 32'(en_mask);
         A_SW_SET:   bus_rdata = 32'(sw_mask);
         A_PROTECT:  bus_rdata = {31'b0, prot_q};
         A_CUR_VEC:  bus_rdata = win_valid ? win_addr : def_addr;
         default: begin
            if (slot_rd_hit)
               bus_rdata = slot_rd_data;
            else if (a[11:4] == R_IDENT)
               bus_rdata = {24'b0, ID_WORD[8*a[3:2] +: 8]};
         end
      endcase
   end

   // R8: unprivileged writes under protection change no source state
   p_prot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q && bus_sel && bus_write && !bus_priv) |=>
         ($stable(en_mask) && $stable(sw_mask) && $stable(route_mask) && $stable(prot_q)));
   // R3: nothing routed to the fast path keeps it quiet
   p_fiq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (route_mask == '0) |-> !fiq_out);
   // R1: an empty mask silences both outputs
   p_mask_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mask == '0) |-> (!irq_out && !fiq_out));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_lines = '0;
   logic        bus_sel = 1'b0, bus_write = 1'b0, bus_priv = 1'b1;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out, fiq_out;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_lines(src_lines),
      .bus_sel(bus_sel), .bus_write(bus_write), .bus_priv(bus_priv),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out), .fiq_out(fiq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] ad, input logic [31:0] d, input bit priv = 1);
      @(negedge clk);
      bus_sel = 1; bus_write = 1; bus_addr = ad; bus_wdata = d; bus_priv = priv;
      @(negedge clk);
      bus_sel = 0; bus_write = 0; bus_priv = 1;
   endtask

   task automatic rd(input logic [11:0] ad, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_write = 0; bus_addr = ad;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(12'h010, d); chk("R9 enable", d, 0);
      rd(12'h018, d); chk("R9 soft", d, 0);
      rd(12'h00C, d); chk("R9 route", d, 0);
      rd(12'h200, d); chk("R9 slot ctl", d, 0);
      rd(12'h030, d); chk("R9 vector", d, 0);
      chk("R9 outputs", {30'b0, irq_out, fiq_out}, 0);
   endtask

   task automatic t_enable;
      logic [31:0] d;
      wr(12'h010, 32'h0000_00F0); rd(12'h010, d); chk("R1 set", d, 32'h0000_00F0);
      wr(12'h010, 32'h0);         rd(12'h010, d); chk("R1 zero set", d, 32'h0000_00F0);
      wr(12'h014, 32'h0000_0030); rd(12'h010, d); chk("R1 clear", d, 32'h0000_00C0);
      wr(12'h014, 32'h0);         rd(12'h010, d); chk("R1 zero clear", d, 32'h0000_00C0);
   endtask

   task automatic t_soft;
      logic [31:0] d;
      wr(12'h018, 32'h0000_0080);
      #1 chk("R2 soft irq", {31'b0, irq_out}, 1);
      src_lines[6] = 1;
      rd(12'h008, d); chk("R2 raw both", d, 32'h0000_00C0);
      wr(12'h01C, 32'h0000_0080);
      rd(12'h008, d); chk("R2 raw after clear", d, 32'h0000_0040);
      src_lines[6] = 0;
      src_lines[1] = 1;
      rd(12'h008, d); chk("R2 raw unmasked", d, 32'h0000_0002);
      #1 chk("R2 masked line quiet", {31'b0, irq_out}, 0);
      src_lines = '0;
      wr(12'h014, 32'hFFFF_FFFF);
   endtask

   task automatic t_route;
      logic [31:0] d;
      wr(12'h010, 32'h0000_0008);
      wr(12'h00C, 32'h0000_0008);
      src_lines[3] = 1;
      #1 chk("R3 fast routed", {30'b0, irq_out, fiq_out}, 32'h1);
      rd(12'h004, d); chk("R3 fast status", d, 32'h0000_0008);
      wr(12'h00C, 32'h0);
      #1 chk("R3 normal routed", {30'b0, irq_out, fiq_out}, 32'h2);
      rd(12'h000, d); chk("R3 normal status", d, 32'h0000_0008);
      src_lines = '0;
      wr(12'h014, 32'hFFFF_FFFF);
   endtask

   task automatic t_vector;
      logic [31:0] d;
      wr(12'h200, 32'h29);        wr(12'h100, 32'h1000);  // slot0 src9
      wr(12'h208, 32'h24);        wr(12'h108, 32'h2000);  // slot2 src4
      wr(12'h214, 32'h2C);        wr(12'h114, 32'h5000);  // slot5 src12
      wr(12'h034, 32'h9000);
      wr(12'h010, 32'h0000_1A10);                         // src 4,9,11,12
      src_lines[4] = 1;
      rd(12'h030, d); chk("R4 slot2 vector", d, 32'h2000);
      src_lines[12] = 1;
      rd(12'h030, d); chk("R6 lower slot blocked", d, 32'h9000);
      src_lines[9] = 1;
      rd(12'h030, d); chk("R6 higher preempts", d, 32'h1000);
      wr(12'h030, 0);
      src_lines[9] = 0;
      rd(12'h030, d); chk("R6 still level2", d, 32'h9000);
      wr(12'h030, 0);
      rd(12'h030, d); chk("R6 after pop", d, 32'h2000);
      src_lines[4] = 0;
      wr(12'h030, 0);
      rd(12'h030, d); chk("R4 slot5 vector", d, 32'h5000);
      wr(12'h030, 0);
      src_lines[12] = 0;
      src_lines[4] = 1; src_lines[9] = 1;
      rd(12'h030, d); chk("R4 slot0 priority", d, 32'h1000);
      wr(12'h030, 0);
      src_lines = '0;
      src_lines[11] = 1;
      rd(12'h030, d); chk("R5 default vector", d, 32'h9000);
      src_lines[9] = 1;
      rd(12'h030, d); chk("R6 slot over default", d, 32'h1000);
      wr(12'h030, 0); wr(12'h030, 0);
      src_lines = '0;
      wr(12'h208, 32'h04);
      src_lines[4] = 1;
      rd(12'h030, d); chk("R10 disabled slot", d, 32'h9000);
      wr(12'h030, 0);
      src_lines = '0;
      wr(12'h014, 32'hFFFF_FFFF);
   endtask

   task automatic t_ident;
      logic [31:0] d, word;
      word = '0;
      for (int k = 0; k < 4; k++) begin
         rd(12'hFE0 + 12'(4*k), d);
         word[8*k +: 8] = d[7:0];
         chk("R7 upper bits zero", {8'b0, d[31:8]}, 0);
      end
      chk("R7 id word", word, 32'h00B5_A1C3);
      chk("R7 vendor", {24'b0, word[19:12]}, 32'h5A);
   endtask

   task automatic t_protect;
      logic [31:0] d;
      wr(12'h020, 32'h1, 1);
      wr(12'h010, 32'h0010_0000, 0);
      rd(12'h010, d); chk("R8 unpriv ignored", d, 0);
      wr(12'h020, 32'h0, 0);
      rd(12'h020, d); chk("R8 protect kept", d, 1);
      wr(12'h010, 32'h0010_0000, 1);
      rd(12'h010, d); chk("R8 priv write", d, 32'h0010_0000);
      wr(12'h020, 32'h0, 1);
      wr(12'h014, 32'h0010_0000, 0);
      rd(12'h010, d); chk("R8 unprotected", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_enable;
      wr(12'h014, 32'hFFFF_FFFF);
      wr(12'h010, 32'h0000_00C0);
      t_soft;
      t_route;
      t_vector;
      t_ident;
      t_protect;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule